// File: doc/BRIEF.md
# E1 Sa-bit transmit insertion controller

This block sits in the transmit path of an E1 line and rewrites the five spare national bits (Sa4 to Sa8) carried in timeslot 0 of the odd-numbered frames of a CRC-4 multiframe. The stream enters one bit per clock, together with a strobe on the first bit of every frame and a strobe on the first bit of frame 0 of every multiframe. For each Sa bit a control register chooses whether the incoming bit is kept or replaced by a bit from a software-loaded nibble. Sa6 also has an automatic mode. In that mode it carries a four-bit status code built from the receive-side E-bit and CRC-4 error flags.

Each Sa bit carries one nibble per submultiframe, one bit in each of the four odd frames, most significant bit first. At the start of every submultiframe the block takes a snapshot of the control word, both buffers and the error flags. A nibble therefore never changes part-way through. Until the first multiframe strobe has been seen, the stream passes through untouched. The output is the input delayed by one clock, with the selected Sa bits replaced.

Top module: `e1_sa_inserter`

## Requirements
- R1: While reset is asserted, `ser_out` and `cfg_illegal` are 0.
- R2: `ser_out` equals the `ser_in` value of the previous clock wherever no Sa bit is replaced. Before the first `mframe_sync` pulse no bit is ever replaced, whatever the control word holds.
- R3: Every bit of the even frames (frame 0 is the frame marked by `mframe_sync`), and every bit of an odd frame outside clock offsets 3 to 7 after `frame_sync`, is passed through unchanged. The clock offset of the `frame_sync` bit is 0. Offsets 3, 4, 5, 6 and 7 carry Sa4, Sa5, Sa6, Sa7 and Sa8.
- R4: Control bit 0 = 0 keeps Sa4. Control bit 0 = 1 sends `sa_buf1[3:0]` on Sa4.
- R5: Control bits 1, 4 and 5 act in the same way for Sa5, Sa7 and Sa8. When a bit is 1, the Sa bit is taken from `sa_buf0[3:0]`, `sa_buf0[11:8]` and `sa_buf0[15:12]` respectively.
- R6: Control bits 3:2 select the Sa6 mode. 00 keeps Sa6. 01 sends `sa_buf0[7:4]`.
- R7: Sa6 mode 10 is automatic. It sends 0011 when both `rx_ebit_err` and `rx_crc_err` are 1, 0001 when only `rx_ebit_err` is 1, 0010 when only `rx_crc_err` is 1, and `sa_buf0[7:4]` when neither is 1.
- R8: A replaced nibble is sent most significant bit first. Bit 3 goes out in frames 1 and 9, bit 2 in frames 3 and 11, bit 1 in frames 5 and 13, and bit 0 in frames 7 and 15.
- R9: The control word, both buffers and both error flags are sampled only on the bit marked offset 0 of frames 0 and 8. A change at any other time has no effect until the next such sample.
- R10: Sa6 mode 11 is illegal and passes Sa6 through. When a sample takes mode 11, `cfg_illegal` is set. It then stays 1 until reset.
- R11: Control bits 7:6 have no effect on `ser_out`.
- R12: Every `mframe_sync` pulse restarts frame numbering at frame 0, including one that arrives in the middle of a multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Incoming E1 bit |
| frame_sync | input | 1 | High on the first bit of each frame |
| mframe_sync | input | 1 | High on the first bit of frame 0 of a multiframe |
| ctrl_mode | input | 8 | Per-Sa-bit insertion control word |
| sa_buf0 | input | 16 | Nibbles for Sa5, Sa6, Sa7, Sa8 (low to high) |
| sa_buf1 | input | 4 | Nibble for Sa4 |
| rx_ebit_err | input | 1 | Latest receive E-bit check reported an error |
| rx_crc_err | input | 1 | Latest local CRC-4 check reported an error |
| ser_out | output | 1 | Outgoing E1 bit, one clock behind `ser_in` |
| cfg_illegal | output | 1 | Sticky flag: illegal Sa6 mode was sampled |

## Verification
The bench first loads a control word that replaces every Sa bit and runs frames without a multiframe strobe. A design that acted before alignment would corrupt those frames. It then changes the control word, buffers and error flags in the middle of a submultiframe. A design that read them live would alter a nibble part-way through. It walks all four error-flag combinations in automatic mode, including the fallback to the buffer. It issues a multiframe strobe at what was frame 5. A design that ignored the strobe would put nibble bits in the wrong frames or at the wrong significance. It also sets the illegal Sa6 mode. A design that did not pass Sa6 through, or let the flag drop afterwards, is caught both on the stream and on `cfg_illegal`.

// File: rtl/sa_pkg.sv
package sa_pkg;

  localparam int NIB_W        = 4;
  localparam int SA_COUNT     = 5;
  localparam int SA_FIRST_POS = 3;
  localparam int SA_LAST_POS  = SA_FIRST_POS + SA_COUNT - 1;
  localparam int SA6_IDX      = 2;
  localparam int SA6_LSB      = 2;
  localparam int CTRL_W       = 8;
  localparam int BUF0_W       = NIB_W * 4;

  typedef enum logic [1:0] {
    SA6_THRU = 2'b00,
    SA6_BUF  = 2'b01,
    SA6_AUTO = 2'b10,
    SA6_BAD  = 2'b11
  } sa6_mode_e;

  typedef struct packed {
    logic [SA_COUNT-1:0]            replace;
    logic [SA_COUNT-1:0][NIB_W-1:0] nib;
  } sa_plan_t;

  function automatic int ctrl_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      3:       return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int buf0_slot(input int idx);
    case (idx)
      1:       return 0;
      2:       return 1;
      3:       return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [NIB_W-1:0] sa6_status(
      input logic             e_err,
      input logic             c_err,
      input logic [NIB_W-1:0] fallback);
    logic [NIB_W-1:0] code;
    case ({e_err, c_err})
      2'b11:   code = NIB_W'(3);
      2'b10:   code = NIB_W'(1);
      2'b01:   code = NIB_W'(2);
      default: code = fallback;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/sa_frame_tracker.sv
module sa_frame_tracker #(
  parameter  int BITS_PER_FRAME = 256,
  parameter  int FRAMES_PER_MF  = 16,
  localparam int BW             = $clog2(BITS_PER_FRAME),
  localparam int FW             = $clog2(FRAMES_PER_MF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  input  logic          mframe_sync,
  output logic [BW-1:0] bit_pos,
  output logic [FW-1:0] frame_pos,
  output logic          aligned,
  output logic          smf_start
);

  localparam int SMF_LEN = FRAMES_PER_MF / 2;
  localparam int SW      = $clog2(SMF_LEN);

  logic [BW-1:0] bit_q, bit_d;
  logic [FW-1:0] frame_q, frame_inc;
  logic          lock_q;

  always_comb begin
    bit_pos   = frame_sync ? '0 : bit_q;
    frame_inc = (frame_q == FW'(FRAMES_PER_MF - 1)) ? '0 : frame_q + 1'b1;
    if (mframe_sync) begin
      frame_pos = '0;
    end else if (bit_pos == '0) begin
      frame_pos = frame_inc;
    end else begin
      frame_pos = frame_q;
    end
    bit_d     = (bit_pos == BW'(BITS_PER_FRAME - 1)) ? '0 : bit_pos + 1'b1;
    aligned   = lock_q | mframe_sync;
    smf_start = aligned && (bit_pos == '0) && (frame_pos[SW-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      frame_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      bit_q   <= bit_d;
      frame_q <= frame_pos;
      lock_q  <= aligned;
    end
  end

endmodule

// File: rtl/sa_sample_bank.sv
module sa_sample_bank
  import sa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smf_start,
  input  logic [CTRL_W-1:0] ctrl_mode,
  input  logic [BUF0_W-1:0] sa_buf0,
  input  logic [NIB_W-1:0]  sa_buf1,
  input  logic              rx_ebit_err,
  input  logic              rx_crc_err,
  output sa_plan_t          plan,
  output logic              cfg_illegal
);

  logic [SA_COUNT-1:0]            rep_d;
  logic [SA_COUNT-1:0][NIB_W-1:0] nib_d;
  sa_plan_t                       plan_d, plan_q;
  logic                           illegal_d, illegal_q;
  sa6_mode_e                      sa6_mode;
  logic                           unused_ebit_mode;

  assign sa6_mode         = sa6_mode_e'(ctrl_mode[SA6_LSB +: 2]);
  assign unused_ebit_mode = ^ctrl_mode[CTRL_W-1:CTRL_W-2];

  for (genvar g = 0; g < SA_COUNT; g++) begin : g_slot
    if (g == 0) begin : g_sa4
      assign rep_d[g] = ctrl_mode[ctrl_pos(g)];
      assign nib_d[g] = sa_buf1;
    end else if (g == SA6_IDX) begin : g_sa6
      logic             rep6;
      logic [NIB_W-1:0] nib6;
      always_comb begin
        rep6 = 1'b0;
        nib6 = sa_buf0[buf0_slot(g)*NIB_W +: NIB_W];
        case (sa6_mode)
          SA6_BUF:  rep6 = 1'b1;
          SA6_AUTO: begin
            rep6 = 1'b1;
            nib6 = sa6_status(rx_ebit_err, rx_crc_err,
                              sa_buf0[buf0_slot(g)*NIB_W +: NIB_W]);
          end
          default:  rep6 = 1'b0;
        endcase
      end
      assign rep_d[g] = rep6;
      assign nib_d[g] = nib6;
    end else begin : g_plain
      assign rep_d[g] = ctrl_mode[ctrl_pos(g)];
      assign nib_d[g] = sa_buf0[buf0_slot(g)*NIB_W +: NIB_W];
    end
  end

  always_comb begin
    plan_d    = plan_q;
    illegal_d = illegal_q;
    if (smf_start) begin
      plan_d.replace = rep_d;
      plan_d.nib     = nib_d;
      illegal_d      = illegal_q | (sa6_mode == SA6_BAD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plan_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      plan_q    <= plan_d;
      illegal_q <= illegal_d;
    end
  end

  assign plan        = plan_q;
  assign cfg_illegal = illegal_q;

endmodule

// File: rtl/sa_bit_mux.sv
module sa_bit_mux
  import sa_pkg::*;
#(
  parameter int BW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_in,
  input  logic          aligned,
  input  logic [BW-1:0] bit_pos,
  input  logic [FW-1:0] frame_pos,
  input  sa_plan_t      plan,
  output logic          ser_out
);

  localparam int NW = $clog2(NIB_W);

  logic                odd_frame;
  logic [NW-1:0]       order, nib_idx;
  logic [SA_COUNT-1:0] slot_hit, rep_bit, val_bit;
  logic                replace_now, out_d, out_q;
  logic                unused_frame_hi;

  assign odd_frame       = frame_pos[0];
  assign order           = frame_pos[NW:1];
  assign nib_idx         = NW'(NIB_W - 1) - order;
  assign unused_frame_hi = ^frame_pos[FW-1:NW+1];

  for (genvar g = 0; g < SA_COUNT; g++) begin : g_slot
    assign slot_hit[g] = (bit_pos == BW'(SA_FIRST_POS + g));
    assign rep_bit[g]  = slot_hit[g] & plan.replace[g];
    assign val_bit[g]  = plan.nib[g][nib_idx];
  end

  always_comb begin
    replace_now = aligned && odd_frame && (|rep_bit);
    out_d       = replace_now ? |(rep_bit & val_bit) : ser_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else begin
      out_q <= out_d;
    end
  end

  assign ser_out = out_q;

endmodule

// File: rtl/e1_sa_inserter.sv
module e1_sa_inserter
  import sa_pkg::*;
#(
  parameter int BITS_PER_FRAME = 256,
  parameter int FRAMES_PER_MF  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              frame_sync,
  input  logic              mframe_sync,
  input  logic [CTRL_W-1:0] ctrl_mode,
  input  logic [BUF0_W-1:0] sa_buf0,
  input  logic [NIB_W-1:0]  sa_buf1,
  input  logic              rx_ebit_err,
  input  logic              rx_crc_err,
  output logic              ser_out,
  output logic              cfg_illegal
);

  localparam int BW = $clog2(BITS_PER_FRAME);
  localparam int FW = $clog2(FRAMES_PER_MF);

  logic          rst_meta_n, rst_core_n;
  logic [BW-1:0] bit_pos;
  logic [FW-1:0] frame_pos;
  logic          aligned, smf_start;
  sa_plan_t      plan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  sa_frame_tracker #(
    .BITS_PER_FRAME (BITS_PER_FRAME),
    .FRAMES_PER_MF  (FRAMES_PER_MF)
  ) u_tracker (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .frame_sync  (frame_sync),
    .mframe_sync (mframe_sync),
    .bit_pos     (bit_pos),
    .frame_pos   (frame_pos),
    .aligned     (aligned),
    .smf_start   (smf_start)
  );

  sa_sample_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .smf_start   (smf_start),
    .ctrl_mode   (ctrl_mode),
    .sa_buf0     (sa_buf0),
    .sa_buf1     (sa_buf1),
    .rx_ebit_err (rx_ebit_err),
    .rx_crc_err  (rx_crc_err),
    .plan        (plan),
    .cfg_illegal (cfg_illegal)
  );

  sa_bit_mux #(
    .BW (BW),
    .FW (FW)
  ) u_mux (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ser_in    (ser_in),
    .aligned   (aligned),
    .bit_pos   (bit_pos),
    .frame_pos (frame_pos),
    .plan      (plan),
    .ser_out   (ser_out)
  );

endmodule

// File: rtl/e1_sa_inserter_chk.sv
module e1_sa_inserter_chk
  import sa_pkg::*;
#(
  parameter  int BITS_PER_FRAME = 256,
  parameter  int FRAMES_PER_MF  = 16,
  localparam int BW             = $clog2(BITS_PER_FRAME),
  localparam int FW             = $clog2(FRAMES_PER_MF)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_in,
  input logic          ser_out,
  input logic          cfg_illegal,
  input logic          aligned,
  input logic [BW-1:0] bit_pos,
  input logic [FW-1:0] frame_pos,
  input logic          smf_start,
  input sa_plan_t      plan
);

  logic past_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  // R2: nothing is replaced before alignment
  assert_unaligned_thru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && $past(!aligned) |-> ser_out == $past(ser_in));

  // R3: even frames are untouched
  assert_fas_frame_thru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && $past(aligned && !frame_pos[0]) |-> ser_out == $past(ser_in));

  // R3: bits outside the Sa window are untouched
  assert_non_sa_thru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && $past(bit_pos < BW'(SA_FIRST_POS) || bit_pos > BW'(SA_LAST_POS))
    |-> ser_out == $past(ser_in));

  // R9: the sampled plan only moves at a submultiframe start
  assert_plan_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && !smf_start |=> $stable(plan));

  // R10: illegal flag is sticky
  assert_illegal_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |=> cfg_illegal);

endmodule

bind e1_sa_inserter e1_sa_inserter_chk #(
  .BITS_PER_FRAME (BITS_PER_FRAME),
  .FRAMES_PER_MF  (FRAMES_PER_MF)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .ser_in      (ser_in),
  .ser_out     (ser_out),
  .cfg_illegal (cfg_illegal),
  .aligned     (aligned),
  .bit_pos     (bit_pos),
  .frame_pos   (frame_pos),
  .smf_start   (smf_start),
  .plan        (plan)
);

// File: tb/test_e1_sa_inserter.sv
`timescale 1ns/1ps
module test_e1_sa_inserter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_in, frame_sync, mframe_sync;
  logic [7:0]  ctrl_mode;
  logic [15:0] sa_buf0;
  logic [3:0]  sa_buf1;
  logic        rx_ebit_err, rx_crc_err;
  logic        ser_out, cfg_illegal;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  bit          m_aligned = 0;
  bit          pend      = 0;
  logic        exp_bit;
  string       exp_tag, scen;
  int          exp_f, exp_b;
  logic [7:0]  l_ctrl;
  logic [15:0] l_b0;
  logic [3:0]  l_b1;
  logic        l_e, l_c;

  always #5 clk = ~clk;

  e1_sa_inserter i_e1_sa_inserter (
    .clk (clk), .rst_n (rst_n), .ser_in (ser_in),
    .frame_sync (frame_sync), .mframe_sync (mframe_sync),
    .ctrl_mode (ctrl_mode), .sa_buf0 (sa_buf0), .sa_buf1 (sa_buf1),
    .rx_ebit_err (rx_ebit_err), .rx_crc_err (rx_crc_err),
    .ser_out (ser_out), .cfg_illegal (cfg_illegal)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input bit fs, input bit ms, input int b, input int f);
    int   k;
    logic [3:0] auto_nib;
    @(negedge clk);
    if (pend) begin
      n_checks++;
      if (ser_out !== exp_bit) begin
        n_fail++;
        $display("FAIL %s [%s] frame %0d bit %0d: actual %0b expected %0b",
                 exp_tag, scen, exp_f, exp_b, ser_out, exp_bit);
      end
    end
    ser_in      = 1'($urandom);
    frame_sync  = fs;
    mframe_sync = ms;
    if (ms) m_aligned = 1;
    exp_bit = ser_in;
    exp_f   = f;
    exp_b   = b;
    if (!m_aligned) begin
      exp_tag = "R2";
    end else begin
      exp_tag = "R3";
      if (b == 0 && f % 8 == 0) begin
        l_ctrl = ctrl_mode; l_b0 = sa_buf0; l_b1 = sa_buf1;
        l_e = rx_ebit_err;  l_c = rx_crc_err;
      end
      if (f % 2 == 1 && b >= 3 && b <= 7) begin
        k = 3 - (f % 8) / 2;
        case (b + 1)
          4: begin exp_tag = "R4"; if (l_ctrl[0]) begin exp_bit = l_b1[k]; exp_tag = "R4/R8"; end end
          5: begin exp_tag = "R5"; if (l_ctrl[1]) begin exp_bit = l_b0[k]; exp_tag = "R5/R8"; end end
          6: begin
            case (l_ctrl[3:2])
              2'b00: exp_tag = "R6";
              2'b01: begin exp_bit = l_b0[4+k]; exp_tag = "R6/R8"; end
              2'b10: begin
                if (l_e && l_c)  auto_nib = 4'b0011;
                else if (l_e)    auto_nib = 4'b0001;
                else if (l_c)    auto_nib = 4'b0010;
                else             auto_nib = l_b0[7:4];
                exp_bit = auto_nib[k];
                exp_tag = "R7/R8";
              end
              default: exp_tag = "R10";
            endcase
          end
          7: begin exp_tag = "R5"; if (l_ctrl[4]) begin exp_bit = l_b0[8+k];  exp_tag = "R5/R8"; end end
          default: begin exp_tag = "R5"; if (l_ctrl[5]) begin exp_bit = l_b0[12+k]; exp_tag = "R5/R8"; end end
        endcase
      end
    end
    pend = 1;
  endtask

  task automatic run_range(input int f_lo, input int f_hi, input bit ms);
    for (int f = f_lo; f <= f_hi; f++)
      for (int b = 0; b < 256; b++)
        tick(b == 0, ms && f == 0 && b == 0, b, f);
  endtask

  initial begin
    #1_900_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_in = 0; frame_sync = 0; mframe_sync = 0;
    ctrl_mode = '0; sa_buf0 = '0; sa_buf1 = '0; rx_ebit_err = 0; rx_crc_err = 0;
    repeat (3) @(negedge clk);
    check(ser_out === 1'b0, "R1 ser_out in reset", int'(ser_out), 0);
    check(cfg_illegal === 1'b0, "R1 cfg_illegal in reset", int'(cfg_illegal), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2: all replacement requested, illegal Sa6 too, but not yet aligned
    scen = "R2 unaligned";
    ctrl_mode = 8'hFF; sa_buf0 = 16'h0000; sa_buf1 = 4'h0;
    run_range(0, 1, 0);
    check(cfg_illegal === 1'b0, "R2 no sample before alignment", int'(cfg_illegal), 0);

    // R3: aligned, everything passes through
    scen = "R3 pass";
    ctrl_mode = 8'h00;
    run_range(0, 15, 1);

    // R4 R5 R6 R8: buffer insertion on all Sa bits
    scen = "R4 R5 R6 R8 buffers";
    ctrl_mode = 8'h37; sa_buf0 = 16'hA5C3; sa_buf1 = 4'h9;
    run_range(0, 15, 1);

    // R11: E-bit mode bits set, other buffer pattern
    scen = "R11 ebit mode bits";
    ctrl_mode = 8'hF7; sa_buf0 = 16'h3C5A; sa_buf1 = 4'h6;
    run_range(0, 15, 1);

    // R7: automatic Sa6 across all four flag combinations
    scen = "R7 auto";
    ctrl_mode = 8'h08; sa_buf0 = 16'h0B00;
    rx_ebit_err = 1; rx_crc_err = 1; run_range(0, 7, 1);
    rx_ebit_err = 1; rx_crc_err = 0; run_range(8, 15, 0);
    rx_ebit_err = 0; rx_crc_err = 1; run_range(0, 7, 1);
    rx_ebit_err = 0; rx_crc_err = 0; run_range(8, 15, 0);

    // R9: mid-submultiframe changes are held off
    scen = "R9 mid change";
    rx_ebit_err = 1; rx_crc_err = 0; ctrl_mode = 8'h0B; sa_buf1 = 4'hE;
    run_range(0, 3, 1);
    rx_ebit_err = 0; rx_crc_err = 1; ctrl_mode = 8'h34; sa_buf0 = 16'h96F1; sa_buf1 = 4'h1;
    run_range(4, 11, 0);
    ctrl_mode = 8'h00;
    run_range(12, 15, 0);

    // R10: illegal Sa6 mode
    scen = "R10 illegal";
    check(cfg_illegal === 1'b0, "R10 flag clear before illegal", int'(cfg_illegal), 0);
    ctrl_mode = 8'h0D; sa_buf1 = 4'h5;
    run_range(0, 15, 1);
    check(cfg_illegal === 1'b1, "R10 flag set", int'(cfg_illegal), 1);
    ctrl_mode = 8'h00;
    run_range(0, 15, 1);
    check(cfg_illegal === 1'b1, "R10 flag sticky", int'(cfg_illegal), 1);

    // R12: multiframe strobe in the middle of a multiframe
    scen = "R12 realign";
    ctrl_mode = 8'h37; sa_buf0 = 16'h5E21; sa_buf1 = 4'hB;
    run_range(0, 4, 0);
    run_range(0, 15, 1);
    run_range(0, 15, 1);

    @(negedge clk);
    check(ser_out === exp_bit, "R2 final bit", int'(ser_out), int'(exp_bit));
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule